// File: doc/BRIEF.md
# Management-Mode Entry and Exit Controller

This block is the mode controller inside a processor core that decides when the core leaves normal execution for a privileged management mode and when it comes back. A management request can't be masked. It beats a non-maskable interrupt that arrives in the same cycle. It is only taken at an instruction boundary. Entry runs a fixed sequence: first a context-save strobe, then a handler-start strobe, and then the in-mode flag rises and stays high.

The core leaves the mode only by decoding a two-byte resume instruction, first byte 0x0F and second byte 0xAA, or through reset. If the resume instruction is decoded outside the mode, the block raises an invalid-opcode fault. If the resume instruction is decoded while the saved state is reported invalid, the block locks into shutdown, and only reset clears it.

The same block also grants non-maskable and maskable interrupts at instruction boundaries, but only in normal execution. Context storage, execution of the handler and coordination between cores live elsewhere.

Top module: `mgmt_mode_ctl`

## Requirements
- R1: While reset is held and directly after it, in_mgmt_o, save_ctx_o, handler_go_o, nmi_ack_o, irq_ack_o, ud_fault_o and shutdown_o are all low.
- R2: A management request is accepted whatever the value of irq_en_i. A low irq_en_i neither blocks nor delays entry.
- R3: In normal execution, suppose mgmt_req_i (or a latched request) and nmi_req_i are both present at a boundary. Then nmi_ack_o stays low in that cycle and entry begins. Likewise, an NMI at a boundary suppresses irq_ack_o.
- R4: Entry starts only in a cycle where insn_boundary_i is high. A one-cycle request pulse that arrives without a boundary is latched and taken at the next boundary.
- R5: If a request and a boundary are both sampled at clock edge k, save_ctx_o is high for the cycle after edge k and handler_go_o is high for the cycle after that. From the following cycle on, in_mgmt_o is high.
- R6: In the mode, suppose dec_valid_i is high with dec_op0_i = 0x0F, dec_op1_i = 0xAA and restore_ok_i high. Then in_mgmt_o is low from the next cycle. Any other byte pair leaves the mode unchanged.
- R7: In normal execution, decoding 0x0F then 0xAA raises ud_fault_o in that same cycle. The mode does not change: no entry, and in_mgmt_o stays low.
- R8: If the resume instruction is decoded in the mode while restore_ok_i is low, shutdown_o rises in the next cycle and in_mgmt_o falls. shutdown_o then stays high, whatever the requests, until reset. In shutdown no interrupt is granted and no entry starts.
- R9: While in the mode, nmi_ack_o and irq_ack_o stay low. A request that arrives in the mode is held as one pending bit and starts a new entry at the first boundary after a successful resume.
- R10: In normal execution, irq_ack_o is high in a boundary cycle when irq_req_i and irq_en_i are high and neither a management request nor an NMI is present. It is low when irq_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_req_i | input | 1 | Management request level, sampled each clock |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_en_i | input | 1 | Interrupt-enable flag for maskable interrupts only |
| insn_boundary_i | input | 1 | High when the core is at an interruptible instruction boundary |
| dec_valid_i | input | 1 | Decoded instruction bytes are valid |
| dec_op0_i | input | OPW | First opcode byte |
| dec_op1_i | input | OPW | Second opcode byte |
| restore_ok_i | input | 1 | Saved state found valid at resume |
| in_mgmt_o | output | 1 | Core is in management mode |
| save_ctx_o | output | 1 | One-cycle strobe to save the context |
| handler_go_o | output | 1 | One-cycle strobe to start the handler |
| nmi_ack_o | output | 1 | NMI granted this cycle |
| irq_ack_o | output | 1 | Maskable interrupt granted this cycle |
| ud_fault_o | output | 1 | Invalid-opcode fault strobe |
| shutdown_o | output | 1 | Latched shutdown state |

## Verification
Two collisions get special attention. The first is a management request and an NMI meeting at the same boundary. The bench holds both high in one boundary cycle, requires nmi_ack_o to stay low in that cycle, and requires save_ctx_o one edge later. The second is a request arriving while the core is already in the mode. The bench pulses the request during the mode, together with NMI and maskable requests, and requires that no grant occurs, that the resume clears in_mgmt_o after one edge, and that the pending bit starts a fresh entry at the next boundary.

// File: rtl/mgmt_mode_ctl.sv
module mgmt_mode_ctl #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] RES_OP0 = 8'h0F,
  parameter logic [OPW-1:0] RES_OP1 = 8'hAA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mgmt_req_i,
  input  logic           nmi_req_i,
  input  logic           irq_req_i,
  input  logic           irq_en_i,
  input  logic           insn_boundary_i,
  input  logic           dec_valid_i,
  input  logic [OPW-1:0] dec_op0_i,
  input  logic [OPW-1:0] dec_op1_i,
  input  logic           restore_ok_i,
  output logic           in_mgmt_o,
  output logic           save_ctx_o,
  output logic           handler_go_o,
  output logic           nmi_ack_o,
  output logic           irq_ack_o,
  output logic           ud_fault_o,
  output logic           shutdown_o
);

  typedef enum logic [2:0] {ST_RUN, ST_SAVE, ST_LAUNCH, ST_MGMT, ST_DEAD} st_t;

  st_t  st, st_nx;
  logic pend;

  wire running = (st == ST_RUN);
  wire wants   = pend | mgmt_req_i;
  wire take    = running & insn_boundary_i & wants;
  wire is_res  = dec_valid_i & (dec_op0_i == RES_OP0) & (dec_op1_i == RES_OP1);

  always_comb begin
    st_nx = st;
    case (st)
      ST_RUN:    if (take) st_nx = ST_SAVE;
      ST_SAVE:   st_nx = ST_LAUNCH;
      ST_LAUNCH: st_nx = ST_MGMT;
      ST_MGMT:   if (is_res) st_nx = restore_ok_i ? ST_RUN : ST_DEAD;
      default:   st_nx = ST_DEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      pend <= 1'b0;
    end else begin
      st   <= st_nx;
      pend <= take ? 1'b0 : wants;
    end
  end

  assign save_ctx_o   = (st == ST_SAVE);
  assign handler_go_o = (st == ST_LAUNCH);
  assign in_mgmt_o    = (st == ST_MGMT);
  assign shutdown_o   = (st == ST_DEAD);
  assign ud_fault_o   = running & is_res;
  assign nmi_ack_o    = running & insn_boundary_i & nmi_req_i & ~wants;
  assign irq_ack_o    = running & insn_boundary_i & irq_req_i & irq_en_i & ~nmi_req_i & ~wants;

endmodule

// File: rtl/mgmt_mode_ctl_chk.sv
module mgmt_mode_ctl_chk #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] RES_OP0 = 8'h0F,
  parameter logic [OPW-1:0] RES_OP1 = 8'hAA
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mgmt_req_i,
  input logic           nmi_req_i,
  input logic           irq_req_i,
  input logic           irq_en_i,
  input logic           insn_boundary_i,
  input logic           dec_valid_i,
  input logic [OPW-1:0] dec_op0_i,
  input logic [OPW-1:0] dec_op1_i,
  input logic           restore_ok_i,
  input logic           in_mgmt_o,
  input logic           save_ctx_o,
  input logic           handler_go_o,
  input logic           nmi_ack_o,
  input logic           irq_ack_o,
  input logic           ud_fault_o,
  input logic           shutdown_o
);

  wire normal = !in_mgmt_o && !save_ctx_o && !handler_go_o && !shutdown_o;
  wire resume = dec_valid_i && dec_op0_i == RES_OP0 && dec_op1_i == RES_OP1;

  assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_ctx_o, handler_go_o, in_mgmt_o, shutdown_o}));
  assert_unmaskable_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    normal && mgmt_req_i && insn_boundary_i |=> save_ctx_o);
  assert_nmi_loses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req_i && nmi_req_i |-> !nmi_ack_o);
  assert_no_entry_off_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    normal && !insn_boundary_i |=> !save_ctx_o);
  assert_save_then_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_ctx_o |=> handler_go_o);
  assert_go_then_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    handler_go_o |=> in_mgmt_o);
  assert_clean_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_mgmt_o && resume && restore_ok_i |=> !in_mgmt_o && !shutdown_o);
  assert_no_fault_in_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault_o |-> normal);
  assert_bad_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_mgmt_o && resume && !restore_ok_i |=> shutdown_o);
  assert_shutdown_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);
  assert_no_grant_in_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !normal |-> !nmi_ack_o && !irq_ack_o);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> irq_en_i && !nmi_ack_o);

endmodule

bind mgmt_mode_ctl mgmt_mode_ctl_chk #(.OPW(OPW), .RES_OP0(RES_OP0), .RES_OP1(RES_OP1)) u_chk (.*);

// File: tb/sim_mgmt_mode_ctl.sv
`timescale 1ns/1ps
module sim_mgmt_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, nmi = 0, irq = 0, ien = 0, bnd = 0, dv = 0, rok = 0;
  logic [7:0] b0 = 8'h00, b1 = 8'h00;
  logic in_m, sv, go, nack, iack, ud, sd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mgmt_mode_ctl u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_req_i(req), .nmi_req_i(nmi), .irq_req_i(irq),
    .irq_en_i(ien), .insn_boundary_i(bnd), .dec_valid_i(dv), .dec_op0_i(b0),
    .dec_op1_i(b1), .restore_ok_i(rok), .in_mgmt_o(in_m), .save_ctx_o(sv),
    .handler_go_o(go), .nmi_ack_o(nack), .irq_ack_o(iack), .ud_fault_o(ud),
    .shutdown_o(sd));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step();
    chk("R1 in_mgmt in reset", in_m, 0);
    chk("R1 shutdown in reset", sd, 0);
    rst_n = 1; step();
    chk("R1 in_mgmt", in_m, 0); chk("R1 save", sv, 0); chk("R1 go", go, 0);
    chk("R1 nmi_ack", nack, 0); chk("R1 irq_ack", iack, 0);
    chk("R1 fault", ud, 0); chk("R1 shutdown", sd, 0);
  endtask

  task automatic finish_entry();
    chk("R5 save strobe", sv, 1); chk("R5 no mode yet", in_m, 0);
    step(); chk("R5 handler strobe", go, 1); chk("R5 save dropped", sv, 0);
    step(); chk("R5 in mode", in_m, 1); chk("R5 handler dropped", go, 0);
  endtask

  task automatic resume_op(input logic ok);
    dv = 1; b0 = 8'h0F; b1 = 8'hAA; rok = ok; #1;
    chk("R7 no fault in mode", ud, 0);
    step(); dv = 0; rok = 0;
  endtask

  task automatic t_masked_entry();
    ien = 0; req = 1; bnd = 1; step(); req = 0; bnd = 0;
    chk("R2 entry with enable low", sv, 1);
    finish_entry();
    resume_op(1);
    chk("R6 mode left", in_m, 0); chk("R6 no shutdown", sd, 0);
  endtask

  task automatic t_priority();
    nmi = 1; irq = 1; ien = 1; bnd = 1; #1;
    chk("R3 nmi granted alone", nack, 1); chk("R3 irq loses to nmi", iack, 0);
    nmi = 0; #1; chk("R10 irq granted", iack, 1);
    ien = 0; #1; chk("R10 irq masked", iack, 0);
    ien = 1; bnd = 0; nmi = 1; #1;
    chk("R10 no irq off boundary", iack, 0); chk("R3 no nmi off boundary", nack, 0);
    bnd = 1; req = 1; #1;
    chk("R3 nmi suppressed by request", nack, 0); chk("R3 irq suppressed", iack, 0);
    step(); req = 0; nmi = 0; irq = 0; bnd = 0;
    chk("R3 request wins entry", sv, 1);
    finish_entry();
    resume_op(1); chk("R6 exit after priority", in_m, 0);
  endtask

  task automatic t_boundary();
    req = 1; bnd = 0; step(); req = 0;
    chk("R4 no entry off boundary", sv, 0);
    step(); step();
    chk("R4 still waiting", sv, 0); chk("R4 not in mode", in_m, 0);
    bnd = 1; step(); bnd = 0;
    chk("R4 latched pulse taken", sv, 1);
    finish_entry();
    resume_op(1); chk("R6 exit after boundary test", in_m, 0);
    step(); bnd = 1; step(); bnd = 0;
    chk("R4 pending cleared by entry", sv, 0);
  endtask

  task automatic t_in_mode();
    req = 1; bnd = 1; step(); req = 0; bnd = 0; finish_entry();
    nmi = 1; irq = 1; ien = 1; bnd = 1; req = 1; #1;
    chk("R9 no nmi grant in mode", nack, 0); chk("R9 no irq grant in mode", iack, 0);
    step(); req = 0; nmi = 0; irq = 0; bnd = 0;
    chk("R9 still in mode", in_m, 1);
    dv = 1; b0 = 8'h0F; b1 = 8'h0B; rok = 1; step(); dv = 0;
    chk("R6 wrong pair keeps mode", in_m, 1);
    dv = 1; b0 = 8'h0E; b1 = 8'hAA; step(); dv = 0;
    chk("R6 wrong first byte keeps mode", in_m, 1);
    resume_op(1);
    chk("R6 exit next cycle", in_m, 0); chk("R9 no immediate reentry", sv, 0);
    bnd = 1; #1; chk("R9 pending blocks nmi", nack, 0);
    step(); bnd = 0;
    chk("R9 pending request serviced", sv, 1);
    finish_entry();
    resume_op(1); chk("R6 second exit", in_m, 0);
  endtask

  task automatic t_fault();
    dv = 1; b0 = 8'h0F; b1 = 8'hAA; rok = 1; #1;
    chk("R7 fault strobe", ud, 1);
    step(); dv = 0; #1;
    chk("R7 fault drops", ud, 0); chk("R7 no entry", sv, 0); chk("R7 mode unchanged", in_m, 0);
    dv = 1; b1 = 8'hAB; #1; chk("R7 other pair no fault", ud, 0);
    dv = 0;
  endtask

  task automatic t_shutdown();
    req = 1; bnd = 1; step(); req = 0; bnd = 0; finish_entry();
    resume_op(0);
    chk("R8 shutdown set", sd, 1); chk("R8 mode cleared", in_m, 0);
    req = 1; bnd = 1; nmi = 1; irq = 1; ien = 1; #1;
    chk("R8 no nmi in shutdown", nack, 0); chk("R8 no irq in shutdown", iack, 0);
    step(); step();
    chk("R8 shutdown held", sd, 1); chk("R8 no entry", sv, 0);
    req = 0; bnd = 0; nmi = 0; irq = 0;
    rst_n = 0; step(); rst_n = 1; step();
    chk("R8 reset clears shutdown", sd, 0); chk("R1 mode low after reset", in_m, 0);
  endtask

  initial begin
    do_reset();
    t_masked_entry();
    t_priority();
    t_boundary();
    t_in_mode();
    t_fault();
    t_shutdown();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule